// File: doc/BRIEF.md
# Hashed Filter Table Probe Engine

This block owns one open-addressed filter table whose size is a power of two. Each slot stores a filter type, a 96-bit match word and a queue id, and it has its own occupancy bit. A command port accepts lookup, insert and delete requests. Each request carries a 32-bit key and a filter spec.

The engine turns the key into a 16-bit hash and a 16-bit odd stride. It visits one slot per clock, starting at the hashed slot and stepping by the stride modulo the table size. It reports the final slot index, the number of probes used and a status code.

The engine also records, for each filter type, the deepest probe count any successful insert has needed. From these records it drives one search-limit field per type. The limit adds a small pipeline margin, which differs between full-match and wildcard types. A parameter selects whether the table serves the transmit side, where the queue id takes part in matching.

Top module: `hfilt_probe_engine`

## Requirements
- R1: The hash starts from 0x1fff XOR key[31:16], mixes with t ^= (t>>3)^(t>>6) then t ^= t>>9, then folds in t ^= (t<<13) ^ key[15:0] and mixes again, all in 16 bits; the first probe goes to hash mod SIZE and a request that succeeds there reports depth 1.
- R2: After an unsuccessful probe the next slot is (slot + ((2*key − 1) mod 65536)) mod SIZE, and the reported depth counts probes from 1.
- R3: A used slot matches a request when type and match word are equal; when TX_TABLE=1 the queue id must also be equal, when TX_TABLE=0 it is ignored.
- R4: An insert succeeds at the first free slot or at a matching used slot. On a matching used slot with req_replace=0 it returns status 3 (already present) and changes nothing; with req_replace=1 it returns status 0 and rewrites the slot.
- R5: If no probe succeeds by depth MAX_PROBE (default 200), an insert returns status 1 (no room) and a lookup or delete returns status 2 (absent), reporting depth MAX_PROBE.
- R6: Each write by an insert raises the recorded depth of the request's type to the reported depth if it is larger; the record never falls otherwise, except under R9.
- R7: Type bit 0 set means wildcard. search_limit field t (bits t*DW upward) equals the recorded depth of type t plus 3 for wildcard types and plus 1 for full-match types. After reset the fields are 1 or 3.
- R8: A delete that finds its spec clears the slot, so a later lookup of that spec reports status 2 and the slot can be reused.
- R9: When a delete leaves the table with no used slot, every recorded depth returns to zero.
- R10: An accepted request raises busy from the next cycle until its single done pulse, which carries status, res_index and res_depth. req_valid is ignored while busy, and no done is produced for an ignored request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 lookup, 1 insert, 2 delete |
| req_replace | input | 1 | Insert may overwrite a matching slot |
| req_key | input | 32 | Hash key |
| req_type | input | TW | Filter type, bit 0 = wildcard |
| req_match | input | MW | Match word |
| req_qid | input | QW | Queue id |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 no room, 2 absent, 3 already present |
| res_index | output | $clog2(SIZE) | Final slot index |
| res_depth | output | DW | Probes used |
| search_limit | output | (2**TW)*DW | Per-type search limits |

## Verification
A wrong hash, stride or occupancy bit shows up on the done pulse of the very next request that touches the affected slot. It appears as a wrong res_index, a wrong depth, or a status that reads present instead of absent. A stale depth record, or a missed reset of the records when the table empties, appears on search_limit in the same cycle as that request's done. Requests whose specs are absent need MAX_PROBE cycles, so a bad give-up counter shows as a depth other than MAX_PROBE or as a watchdog expiry. The scoreboard keeps a full model of the table, so errors in earlier state surface at the first later request that probes the slot.

// File: rtl/hfilt_pkg.sv
package hfilt_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_INSERT = 2'd1,
    OP_DELETE = 2'd2
  } hf_op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_NOROOM  = 2'd1,
    ST_ABSENT  = 2'd2,
    ST_PRESENT = 2'd3
  } hf_status_e;

  // two shift/xor rounds shared by both hash phases
  function automatic logic [15:0] hf_mix(input logic [15:0] v);
    logic [15:0] t;
    t = v ^ (v >> 3) ^ (v >> 6);
    t = t ^ (t >> 9);
    return t;
  endfunction

  function automatic logic [15:0] hf_hash(input logic [31:0] key);
    logic [15:0] t;
    t = hf_mix(16'h1fff ^ key[31:16]);
    t = hf_mix(t ^ (t << 13) ^ key[15:0]);
    return t;
  endfunction

  // always odd, so every slot of a power-of-two table is reachable
  function automatic logic [15:0] hf_stride(input logic [31:0] key);
    return {key[14:0], 1'b0} - 16'd1;
  endfunction
endpackage

// File: rtl/hfilt_store.sv
module hfilt_store #(
  parameter int SIZE = 16,
  parameter int MW   = 96,
  parameter int QW   = 8,
  parameter int TW   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SIZE)-1:0] rd_idx,
  output logic                    rd_used,
  output logic [TW-1:0]           rd_type,
  output logic [MW-1:0]           rd_match,
  output logic [QW-1:0]           rd_qid,
  input  logic                    wr_en,
  input  logic                    wr_clr,
  input  logic [$clog2(SIZE)-1:0] wr_idx,
  input  logic [TW-1:0]           wr_type,
  input  logic [MW-1:0]           wr_match,
  input  logic [QW-1:0]           wr_qid,
  output logic                    went_empty
);
  localparam int CW = $clog2(SIZE) + 1;

  logic [SIZE-1:0] used;
  logic [TW-1:0]   e_type  [SIZE];
  logic [MW-1:0]   e_match [SIZE];
  logic [QW-1:0]   e_qid   [SIZE];
  logic [CW-1:0]   occ;

  assign rd_used  = used[rd_idx];
  assign rd_type  = e_type[rd_idx];
  assign rd_match = e_match[rd_idx];
  assign rd_qid   = e_qid[rd_idx];

  assign went_empty = wr_en && wr_clr && used[wr_idx] && (occ == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      occ  <= '0;
      for (int i = 0; i < SIZE; i++) begin
        e_type[i]  <= '0;
        e_match[i] <= '0;
        e_qid[i]   <= '0;
      end
    end else if (wr_en) begin
      if (wr_clr) begin
        if (used[wr_idx]) occ <= occ - CW'(1);
        used[wr_idx]    <= 1'b0;
        e_type[wr_idx]  <= '0;
        e_match[wr_idx] <= '0;
        e_qid[wr_idx]   <= '0;
      end else begin
        if (!used[wr_idx]) occ <= occ + CW'(1);
        used[wr_idx]    <= 1'b1;
        e_type[wr_idx]  <= wr_type;
        e_match[wr_idx] <= wr_match;
        e_qid[wr_idx]   <= wr_qid;
      end
    end
  end
endmodule

// File: rtl/hfilt_depth.sv
module hfilt_depth #(
  parameter int TW       = 2,
  parameter int DW       = 8,
  parameter int FULL_PAD = 1,
  parameter int WILD_PAD = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_en,
  input  logic [TW-1:0]          upd_type,
  input  logic [DW-1:0]          upd_depth,
  input  logic                   clr_all,
  output logic [(1<<TW)*DW-1:0]  limits
);
  localparam int NT = 1 << TW;

  logic [DW-1:0] rec [NT];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      for (int i = 0; i < NT; i++) rec[i] <= '0;
    end else if (upd_en && (upd_depth > rec[upd_type])) begin
      rec[upd_type] <= upd_depth;
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_lim
    if (g % 2 == 1) begin : g_wild
      assign limits[g*DW +: DW] = rec[g] + DW'(WILD_PAD);
    end else begin : g_full
      assign limits[g*DW +: DW] = rec[g] + DW'(FULL_PAD);
    end
  end
endmodule

// File: rtl/hfilt_walk.sv
module hfilt_walk
  import hfilt_pkg::*;
#(
  parameter int SIZE      = 16,
  parameter int MW        = 96,
  parameter int QW        = 8,
  parameter int TW        = 2,
  parameter int DW        = 8,
  parameter int MAX_PROBE = 200,
  parameter bit TX_TABLE  = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic                    req_replace,
  input  logic [31:0]             req_key,
  input  logic [TW-1:0]           req_type,
  input  logic [MW-1:0]           req_match,
  input  logic [QW-1:0]           req_qid,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              status,
  output logic [$clog2(SIZE)-1:0] res_index,
  output logic [DW-1:0]           res_depth,
  output logic [$clog2(SIZE)-1:0] rd_idx,
  input  logic                    rd_used,
  input  logic [TW-1:0]           rd_type,
  input  logic [MW-1:0]           rd_match,
  input  logic [QW-1:0]           rd_qid,
  output logic                    wr_en,
  output logic                    wr_clr,
  output logic [TW-1:0]           wr_type,
  output logic [MW-1:0]           wr_match,
  output logic [QW-1:0]           wr_qid,
  output logic                    upd_en,
  output logic [DW-1:0]           upd_depth,
  output logic                    probe_hit,
  output logic                    probe_quit
);
  localparam int IW = $clog2(SIZE);

  logic          active;
  hf_op_e        l_op;
  logic          l_rep;
  logic [TW-1:0] l_type;
  logic [MW-1:0] l_match;
  logic [QW-1:0] l_qid;
  logic [IW-1:0] l_step;
  logic [IW-1:0] cur;
  logic [DW-1:0] depth;
  logic          same;
  hf_status_e    fin_st;

  assign busy   = active;
  assign rd_idx = cur;

  assign same = rd_used && (rd_type == l_type) && (rd_match == l_match) &&
                (!TX_TABLE || (rd_qid == l_qid));

  assign probe_hit  = active && (rd_used ? same : (l_op == OP_INSERT));
  assign probe_quit = active && !probe_hit && (depth == DW'(MAX_PROBE));

  always_comb begin
    wr_en  = 1'b0;
    wr_clr = 1'b0;
    if (probe_hit) begin
      if (l_op == OP_INSERT && (!rd_used || l_rep)) wr_en = 1'b1;
      if (l_op == OP_DELETE) begin
        wr_en  = 1'b1;
        wr_clr = 1'b1;
      end
    end
  end

  assign wr_type   = l_type;
  assign wr_match  = l_match;
  assign wr_qid    = l_qid;
  assign upd_en    = wr_en && !wr_clr;
  assign upd_depth = depth;

  always_comb begin
    if (probe_quit)
      fin_st = (l_op == OP_INSERT) ? ST_NOROOM : ST_ABSENT;
    else if (l_op == OP_INSERT && rd_used && !l_rep)
      fin_st = ST_PRESENT;
    else
      fin_st = ST_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      done      <= 1'b0;
      status    <= 2'd0;
      res_index <= '0;
      res_depth <= '0;
      l_op      <= OP_LOOKUP;
      l_rep     <= 1'b0;
      l_type    <= '0;
      l_match   <= '0;
      l_qid     <= '0;
      l_step    <= '0;
      cur       <= '0;
      depth     <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (req_valid) begin
          active  <= 1'b1;
          l_op    <= hf_op_e'(req_op);
          l_rep   <= req_replace;
          l_type  <= req_type;
          l_match <= req_match;
          l_qid   <= req_qid;
          cur     <= IW'(hf_hash(req_key));
          l_step  <= IW'(hf_stride(req_key));
          depth   <= DW'(1);
        end
      end else if (probe_hit || probe_quit) begin
        active    <= 1'b0;
        done      <= 1'b1;
        status    <= fin_st;
        res_index <= cur;
        res_depth <= depth;
      end else begin
        cur   <= cur + l_step;
        depth <= depth + DW'(1);
      end
    end
  end
endmodule

// File: rtl/hfilt_probe_engine.sv
module hfilt_probe_engine #(
  parameter int SIZE      = 16,
  parameter int MW        = 96,
  parameter int QW        = 8,
  parameter int TW        = 2,
  parameter int DW        = 8,
  parameter int MAX_PROBE = 200,
  parameter int FULL_PAD  = 1,
  parameter int WILD_PAD  = 3,
  parameter bit TX_TABLE  = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic                    req_replace,
  input  logic [31:0]             req_key,
  input  logic [TW-1:0]           req_type,
  input  logic [MW-1:0]           req_match,
  input  logic [QW-1:0]           req_qid,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              status,
  output logic [$clog2(SIZE)-1:0] res_index,
  output logic [DW-1:0]           res_depth,
  output logic [(1<<TW)*DW-1:0]   search_limit
);
  localparam int IW = $clog2(SIZE);

  logic [IW-1:0] rd_idx;
  logic          rd_used;
  logic [TW-1:0] rd_type;
  logic [MW-1:0] rd_match;
  logic [QW-1:0] rd_qid;
  logic          wr_en, wr_clr;
  logic [TW-1:0] wr_type;
  logic [MW-1:0] wr_match;
  logic [QW-1:0] wr_qid;
  logic          upd_en;
  logic [DW-1:0] upd_depth;
  logic          went_empty;
  logic          probe_hit, probe_quit;

  hfilt_walk #(
    .SIZE(SIZE), .MW(MW), .QW(QW), .TW(TW), .DW(DW),
    .MAX_PROBE(MAX_PROBE), .TX_TABLE(TX_TABLE)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_replace(req_replace),
    .req_key(req_key), .req_type(req_type), .req_match(req_match), .req_qid(req_qid),
    .busy(busy), .done(done), .status(status),
    .res_index(res_index), .res_depth(res_depth),
    .rd_idx(rd_idx), .rd_used(rd_used), .rd_type(rd_type),
    .rd_match(rd_match), .rd_qid(rd_qid),
    .wr_en(wr_en), .wr_clr(wr_clr), .wr_type(wr_type),
    .wr_match(wr_match), .wr_qid(wr_qid),
    .upd_en(upd_en), .upd_depth(upd_depth),
    .probe_hit(probe_hit), .probe_quit(probe_quit)
  );

  hfilt_store #(.SIZE(SIZE), .MW(MW), .QW(QW), .TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_used(rd_used), .rd_type(rd_type),
    .rd_match(rd_match), .rd_qid(rd_qid),
    .wr_en(wr_en), .wr_clr(wr_clr), .wr_idx(rd_idx),
    .wr_type(wr_type), .wr_match(wr_match), .wr_qid(wr_qid),
    .went_empty(went_empty)
  );

  hfilt_depth #(.TW(TW), .DW(DW), .FULL_PAD(FULL_PAD), .WILD_PAD(WILD_PAD)) u_depth (
    .clk(clk), .rst_n(rst_n),
    .upd_en(upd_en), .upd_type(wr_type), .upd_depth(upd_depth),
    .clr_all(went_empty), .limits(search_limit)
  );
endmodule

// File: rtl/hfilt_probe_checker.sv
module hfilt_probe_checker #(
  parameter int TW        = 2,
  parameter int DW        = 8,
  parameter int MAX_PROBE = 200,
  parameter int FULL_PAD  = 1,
  parameter int WILD_PAD  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  busy,
  input logic                  done,
  input logic [1:0]            status,
  input logic [DW-1:0]         res_depth,
  input logic                  went_empty,
  input logic                  probe_hit,
  input logic                  probe_quit,
  input logic [(1<<TW)*DW-1:0] search_limit
);
  // R10: completion is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: probing starts only from an accepted request
  p_busy_from_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R10: a finishing probe ends the busy phase with a done pulse
  p_finish_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_hit || probe_quit) |=> (done && !busy));

  // R5: give-up statuses report the full probe budget
  p_giveup_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status == 2'd1 || status == 2'd2)) |-> (res_depth == DW'(MAX_PROBE)));

  // R2: depth of a result is within 1..MAX_PROBE
  p_depth_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_depth != '0 && res_depth <= DW'(MAX_PROBE)));

  // R9: emptying the table brings the limits back to bare padding
  p_empty_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    went_empty |=> (search_limit[DW-1:0] == DW'(FULL_PAD) &&
                    search_limit[2*DW-1:DW] == DW'(WILD_PAD)));
endmodule

bind hfilt_probe_engine hfilt_probe_checker #(
  .TW(TW), .DW(DW), .MAX_PROBE(MAX_PROBE), .FULL_PAD(FULL_PAD), .WILD_PAD(WILD_PAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .status(status), .res_depth(res_depth), .went_empty(went_empty),
  .probe_hit(probe_hit), .probe_quit(probe_quit), .search_limit(search_limit)
);

// File: tb/sim_hfilt_probe_engine.sv
module sim_hfilt_probe_engine;
  localparam int SIZE = 16;
  localparam int MAXP = 200;
  localparam int NT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic        req_replace = 1'b0;
  logic [31:0] req_key = '0;
  logic [1:0]  req_type = '0;
  logic [95:0] req_match = '0;
  logic [7:0]  req_qid = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic [3:0]  res_index;
  logic [7:0]  res_depth;
  logic [31:0] search_limit;

  logic        t_valid = 1'b0;
  logic        t_busy, t_done;
  logic [1:0]  t_status;
  logic [3:0]  t_index;
  logic [7:0]  t_depth;
  logic [31:0] t_limit;

  hfilt_probe_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_replace(req_replace), .req_key(req_key), .req_type(req_type),
    .req_match(req_match), .req_qid(req_qid), .busy(busy), .done(done),
    .status(status), .res_index(res_index), .res_depth(res_depth),
    .search_limit(search_limit)
  );

  hfilt_probe_engine #(.TX_TABLE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(t_valid), .req_op(req_op),
    .req_replace(req_replace), .req_key(req_key), .req_type(req_type),
    .req_match(req_match), .req_qid(req_qid), .busy(t_busy), .done(t_done),
    .status(t_status), .res_index(t_index), .res_depth(t_depth),
    .search_limit(t_limit)
  );

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [1:0]  st;
    logic [3:0]  idx;
    logic [7:0]  dep;
    logic [31:0] lim;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  // reference model of the RX table
  bit          m_used  [SIZE];
  logic [1:0]  m_type  [SIZE];
  logic [95:0] m_match [SIZE];
  int          m_dep   [NT];
  int          m_cnt;

  function automatic int ref_hash(int unsigned key);
    int unsigned t;
    t = 32'h1fff ^ (key >> 16);
    t = (t ^ (t >> 3) ^ (t >> 6)) & 32'hffff;
    t = (t ^ (t >> 9)) & 32'hffff;
    t = (t ^ (t << 13) ^ (key & 32'hffff)) & 32'hffff;
    t = (t ^ (t >> 3) ^ (t >> 6)) & 32'hffff;
    t = (t ^ (t >> 9)) & 32'hffff;
    return int'(t);
  endfunction

  function automatic int ref_stride(int unsigned key);
    return int'((key * 2 - 1) & 32'hffff);
  endfunction

  function automatic logic [31:0] ref_limits();
    logic [31:0] v;
    for (int t = 0; t < NT; t++) v[t*8 +: 8] = 8'(m_dep[t] + ((t % 2 == 1) ? 3 : 1));
    return v;
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // driver: model the request, queue its expectation, present it to u0
  task automatic drive0(input logic [1:0] op, input bit rep, input logic [31:0] key,
                        input logic [1:0] ty, input logic [95:0] mt, input logic [7:0] qd,
                        input string tag);
    exp_t e;
    int idx, stp, d;
    bit hit;
    idx = ref_hash(key) % SIZE;
    stp = ref_stride(key);
    hit = 0;
    d = MAXP;
    for (int n = 1; n <= MAXP; n++) begin
      bit eq;
      eq = m_used[idx] && (m_type[idx] == ty) && (m_match[idx] == mt);
      if (m_used[idx] ? eq : (op == 2'd1)) begin
        hit = 1;
        d = n;
        break;
      end
      if (n < MAXP) idx = (idx + stp) % SIZE;
    end
    e.idx = 4'(idx);
    e.dep = 8'(d);
    e.tag = tag;
    if (!hit) e.st = (op == 2'd1) ? 2'd1 : 2'd2;
    else if (op == 2'd1 && m_used[idx] && !rep) e.st = 2'd3;
    else begin
      e.st = 2'd0;
      if (op == 2'd1) begin
        if (!m_used[idx]) m_cnt++;
        m_used[idx] = 1; m_type[idx] = ty; m_match[idx] = mt;
        if (d > m_dep[ty]) m_dep[ty] = d;
      end else if (op == 2'd2) begin
        m_used[idx] = 0; m_type[idx] = '0; m_match[idx] = '0;
        m_cnt--;
        if (m_cnt == 0) for (int t = 0; t < NT; t++) m_dep[t] = 0;
      end
    end
    e.lim = ref_limits();
    @(negedge clk);
    while (busy) @(negedge clk);
    req_op = op; req_replace = rep; req_key = key; req_type = ty;
    req_match = mt; req_qid = qd;
    sbq.push_back(e);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare each completion with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        check(0, "R10 done without accepted request", 64'(status), 64'hff);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(status == e.st, {e.tag, " status"}, 64'(status), 64'(e.st));
        if (e.st == 2'd0 || e.st == 2'd3)
          check(res_index == e.idx, {e.tag, " index"}, 64'(res_index), 64'(e.idx));
        check(res_depth == e.dep, {e.tag, " depth"}, 64'(res_depth), 64'(e.dep));
        check(search_limit == e.lim, {e.tag, " R7 limits"}, 64'(search_limit), 64'(e.lim));
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    while (busy || sbq.size() != 0) @(negedge clk);
  endtask

  task automatic run1(input logic [1:0] op, input logic [31:0] key, input logic [7:0] qd,
                      input logic [1:0] est, input int eidx, input int edep, input string tag);
    @(negedge clk);
    while (t_busy) @(negedge clk);
    req_op = op; req_replace = 1'b0; req_key = key; req_type = 2'd0;
    req_match = 96'h5a5a; req_qid = qd;
    t_valid = 1'b1;
    @(negedge clk);
    t_valid = 1'b0;
    while (!t_done) @(negedge clk);
    check(t_status == est, {tag, " status"}, 64'(t_status), 64'(est));
    if (est == 2'd0) check(t_index == 4'(eidx), {tag, " index"}, 64'(t_index), 64'(eidx));
    check(t_depth == 8'(edep), {tag, " depth"}, 64'(t_depth), 64'(edep));
  endtask

  function automatic int find_collider(int unsigned base, int unsigned avoid);
    int unsigned k;
    k = base;
    while ((ref_hash(k) % SIZE) != (ref_hash(avoid) % SIZE) || k == avoid) k++;
    return int'(k);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned ka, kb, kc, ki;
    int h1, s1;
    for (int i = 0; i < SIZE; i++) begin
      m_used[i] = 0; m_type[i] = '0; m_match[i] = '0;
    end
    for (int t = 0; t < NT; t++) m_dep[t] = 0;
    m_cnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state R10, R7
    check(!busy && !done, "R10 idle after reset", 64'({busy, done}), 64'(0));
    check(search_limit == 32'h03010301, "R7 limits after reset", 64'(search_limit), 64'h03010301);

    ka = 32'h1234_5678;
    kb = 32'(find_collider(32'h0000_1000, ka));
    kc = 32'h0bad_cafe;
    ki = 32'h7777_0001;

    drive0(2'd1, 0, ka, 2'd0, 96'hA1, 8'd1, "R1 insert first slot");
    drive0(2'd0, 0, ka, 2'd0, 96'hA1, 8'd1, "R1 lookup found");
    drive0(2'd1, 0, ka, 2'd0, 96'hA1, 8'd2, "R4 insert present no replace");
    drive0(2'd1, 1, ka, 2'd0, 96'hA1, 8'd3, "R4 insert replace");
    drive0(2'd1, 0, kb, 2'd0, 96'hB2, 8'd1, "R2 collision second slot R6");
    drive0(2'd0, 0, kb, 2'd0, 96'hB2, 8'd9, "R3 rx qid ignored");
    drive0(2'd0, 0, ka, 2'd2, 96'hA1, 8'd1, "R3 type mismatch absent");
    drive0(2'd1, 0, kc, 2'd1, 96'hC3, 8'd4, "R7 wildcard insert");

    // R10: a request during a long probe is ignored
    drive0(2'd0, 0, ki, 2'd0, 96'hEE, 8'd0, "R10 long lookup");
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R10 busy while probing", 64'(busy), 64'(1));
    req_op = 2'd1; req_key = ki; req_type = 2'd0; req_match = 96'hEE; req_replace = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    drive0(2'd0, 0, ki, 2'd0, 96'hEE, 8'd0, "R10 ignored insert left no entry");

    drive0(2'd2, 0, kb, 2'd0, 96'hB2, 8'd0, "R8 delete found");
    drive0(2'd0, 0, kb, 2'd0, 96'hB2, 8'd0, "R8 lookup after delete");
    drive0(2'd2, 0, kb, 2'd0, 96'hB2, 8'd0, "R5 delete absent");
    drive0(2'd1, 0, kb, 2'd0, 96'hB2, 8'd0, "R8 slot reused");
    drive0(2'd2, 0, kb, 2'd0, 96'hB2, 8'd0, "R6 delete keeps records");
    drive0(2'd2, 0, ka, 2'd0, 96'hA1, 8'd0, "R6 delete A");
    drive0(2'd2, 0, kc, 2'd1, 96'hC3, 8'd0, "R9 last delete resets records");

    // R5: fill the table and overflow
    for (int i = 0; i < SIZE; i++)
      drive0(2'd1, 0, 32'(32'h100 + i * 37), 2'd2, 96'(32'h400 + i), 8'd0, "R6 fill");
    drive0(2'd1, 0, 32'h00ab_0001, 2'd2, 96'h999, 8'd0, "R5 insert into full table");
    drive0(2'd0, 0, 32'h00ab_0001, 2'd2, 96'h999, 8'd0, "R5 lookup in full table");
    drain();

    // R3: transmit table compares queue ids
    h1 = ref_hash(32'h0042_0042) % SIZE;
    s1 = ref_stride(32'h0042_0042);
    run1(2'd1, 32'h0042_0042, 8'd5, 2'd0, h1, 1, "R3 tx insert");
    run1(2'd0, 32'h0042_0042, 8'd6, 2'd2, 0, MAXP, "R3 tx other qid absent");
    run1(2'd1, 32'h0042_0042, 8'd6, 2'd0, (h1 + s1) % SIZE, 2, "R3 tx other qid new slot");
    run1(2'd0, 32'h0042_0042, 8'd5, 2'd0, h1, 1, "R3 tx same qid found");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule